// File: doc/BRIEF.md
# Transfer Overflow and Underflow Monitor

This block watches one command's data phase and compares the bytes the device actually moves against the byte budget that the command's scatter-gather descriptors allow. At command start it captures the budget, the direction, whether the transfer is DMA or PIO, and whether the command is a native queued one. It then adds up the byte count of every data frame until the frame marked last. The data path reports each frame's size, each DMA-activate event and each PIO setup event, together with the transfer length that the setup carries.

When the device moves more data than the descriptors cover, the block sets a sticky overflow status bit. Software clears that bit by writing one. The interrupt request is the status bit gated by a per-port enable and a global enable. The rules depend on the transfer:

- A read, whether PIO or DMA, is always checked.
- A DMA write can only be caught when another DMA-activate arrives after the budget is used up. In that case the block also asks the data path to terminate the transfer.
- A PIO write is judged from the length in its setup frame.
- Both write checks are optional and are switched on by a configuration input.
- A read that ends short of the budget reloads the descriptor byte count with the bytes actually received.
- Queued commands skip every check.

Top module: `tovf_monitor`

## Requirements
- R1: After reset, ovf_status, ovf_irq and xfer_term_req are 0 and prd_byte_cnt is 0.
- R2: On cmd_start, prd_byte_cnt takes the value of cmd_budget and xfer_term_req returns to 0 on the next cycle. The running byte total restarts at zero, and frame, activate and setup inputs in the start cycle are ignored. ovf_status is not changed by cmd_start.
- R3: On a non-queued read (cmd_is_read=1, PIO or DMA), the cycle after an accepted frame that takes the running total above the budget, ovf_status is 1.
- R4: ovf_irq is 1 exactly when ovf_status, port_ovf_ie and glb_ie are all 1. It is combinational from these three.
- R5: ovf_status stays 1 until a cycle with ovf_clr=1, and it reads 0 on the cycle after that clear. An overflow event in the same cycle as ovf_clr wins, and the status stays 1.
- R6: On a non-queued DMA write (cmd_is_read=0, cmd_is_dma=1) with wr_ovf_chk_en=1, a dma_activate while the total is at or above the budget sets ovf_status and xfer_term_req on the next cycle. xfer_term_req then holds until the next cmd_start. A dma_activate below the budget has no effect.
- R7: On a non-queued PIO write (cmd_is_read=0, cmd_is_dma=0) with wr_ovf_chk_en=1, a pio_setup whose pio_xfer_len added to the running total exceeds the budget sets ovf_status on the next cycle. A setup that fits has no effect.
- R8: With wr_ovf_chk_en=0, write overflows of either type leave ovf_status and xfer_term_req at 0.
- R9: On a non-queued read, a last frame that brings the total below the budget loads prd_byte_cnt with that total on the next cycle. A total equal to the budget leaves prd_byte_cnt unchanged, and write commands never update it.
- R10: With cmd_queued=1, no overflow, termination or byte-count update occurs.
- R11: After a read overflow, counting continues, ovf_status stays set, and xfer_term_req stays 0.
- R12: Frames that arrive after the last frame of a command, and before the next cmd_start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command start pulse; captures the attributes below |
| cmd_budget | input | CNT_W | Total bytes described by the descriptors |
| cmd_is_read | input | 1 | 1 = device-to-host data |
| cmd_is_dma | input | 1 | 1 = DMA transfer, 0 = PIO |
| cmd_queued | input | 1 | 1 = native queued command (checks bypassed) |
| frm_valid | input | 1 | A data frame completed this cycle |
| frm_bytes | input | FRM_W | Byte count of that frame |
| frm_last | input | 1 | The frame is the last of the command |
| dma_activate | input | 1 | DMA-activate event from the device |
| pio_setup | input | 1 | PIO setup event from the device |
| pio_xfer_len | input | FRM_W | Transfer length carried by the PIO setup |
| wr_ovf_chk_en | input | 1 | Enables optional write overflow flagging |
| port_ovf_ie | input | 1 | Per-port overflow interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the status |
| ovf_status | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Gated overflow interrupt request |
| prd_byte_cnt | output | CNT_W | Descriptor byte count (budget, or received total after read underflow) |
| xfer_term_req | output | 1 | Request to terminate a DMA write |

## Verification
A corrupted running total or budget shows up one cycle after the next frame, activate or setup event. It appears either as a spurious or missing rise of ovf_status, or as a wrong value loaded into prd_byte_cnt at the last read frame. A stale command attribute, such as direction, type or queued flag, makes the wrong check fire on that same first event. A lost active flag shows when frames that should be ignored after the last frame move the status. Status and termination state errors persist visibly, because both outputs are sticky and can be compared directly against the clear and start strobes on every cycle.

// File: rtl/tovf_pkg.sv
package tovf_pkg;

    typedef struct packed {
        logic active;
        logic is_read;
        logic is_dma;
        logic queued;
    } cmd_attr_t;

    typedef enum logic [1:0] {
        XK_BYPASS = 2'd0,
        XK_READ   = 2'd1,
        XK_DMA_WR = 2'd2,
        XK_PIO_WR = 2'd3
    } xfer_kind_e;

    function automatic xfer_kind_e classify(input cmd_attr_t a);
        if (!a.active || a.queued) return XK_BYPASS;
        if (a.is_read)             return XK_READ;
        if (a.is_dma)              return XK_DMA_WR;
        return XK_PIO_WR;
    endfunction

endpackage

// File: rtl/tovf_tracker.sv
module tovf_tracker
    import tovf_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int FRM_W    = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_budget,
    input  logic             cmd_is_read,
    input  logic             cmd_is_dma,
    input  logic             cmd_queued,
    input  logic             frm_valid,
    input  logic [FRM_W-1:0] frm_bytes,
    input  logic             frm_last,
    output cmd_attr_t        attr_o,
    output logic [CNT_W-1:0] budget_o,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] sum_o,
    output logic             frm_acc_o
);
    localparam int PAD_W = CNT_W + 1 - FRM_W;

    typedef struct packed {
        cmd_attr_t        attr;
        logic [CNT_W-1:0] budget;
        logic [CNT_W-1:0] total;
    } trk_state_t;

    trk_state_t st_q, st_d;
    logic [CNT_W:0]   sum_wide;
    logic [CNT_W-1:0] sum_lim;
    logic             acc;

    assign sum_wide = {1'b0, st_q.total} + {{PAD_W{1'b0}}, frm_bytes};

    generate
        if (SATURATE) begin : g_sat
            assign sum_lim = sum_wide[CNT_W] ? {CNT_W{1'b1}} : sum_wide[CNT_W-1:0];
        end else begin : g_wrap
            assign sum_lim = sum_wide[CNT_W-1:0];
        end
    endgenerate

    assign acc = frm_valid && st_q.attr.active && !cmd_start;

    always_comb begin
        st_d = st_q;
        if (cmd_start) begin
            st_d.attr.active  = 1'b1;
            st_d.attr.is_read = cmd_is_read;
            st_d.attr.is_dma  = cmd_is_dma;
            st_d.attr.queued  = cmd_queued;
            st_d.budget       = cmd_budget;
            st_d.total        = '0;
        end else if (acc) begin
            st_d.total = sum_lim;
            if (frm_last) st_d.attr.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign attr_o    = st_q.attr;
    assign budget_o  = st_q.budget;
    assign total_o   = st_q.total;
    assign sum_o     = sum_lim;
    assign frm_acc_o = acc;

endmodule

// File: rtl/tovf_detect.sv
module tovf_detect
    import tovf_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int FRM_W = 16
) (
    input  cmd_attr_t        attr,
    input  logic [CNT_W-1:0] budget,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] sum,
    input  logic             frm_acc,
    input  logic             frm_last,
    input  logic             cmd_start,
    input  logic             dma_activate,
    input  logic             pio_setup,
    input  logic [FRM_W-1:0] pio_xfer_len,
    input  logic             wr_ovf_chk_en,
    output logic             ovf_evt,
    output logic             term_evt,
    output logic             udf_evt,
    output logic [CNT_W-1:0] udf_cnt
);
    localparam int PAD_W = CNT_W + 1 - FRM_W;

    xfer_kind_e     kind;
    logic [CNT_W:0] pio_need;

    assign kind     = classify(attr);
    assign pio_need = {1'b0, total} + {{PAD_W{1'b0}}, pio_xfer_len};

    always_comb begin
        ovf_evt  = 1'b0;
        term_evt = 1'b0;
        udf_evt  = 1'b0;
        udf_cnt  = sum;
        if (!cmd_start) begin
            unique case (kind)
                XK_READ: begin
                    if (frm_acc && (sum > budget)) ovf_evt = 1'b1;
                    if (frm_acc && frm_last && (sum < budget)) udf_evt = 1'b1;
                end
                XK_DMA_WR: begin
                    if (dma_activate && wr_ovf_chk_en && (total >= budget)) begin
                        ovf_evt  = 1'b1;
                        term_evt = 1'b1;
                    end
                end
                XK_PIO_WR: begin
                    if (pio_setup && wr_ovf_chk_en && (pio_need > {1'b0, budget}))
                        ovf_evt = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tovf_status.sv
module tovf_status #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_budget,
    input  logic             ovf_evt,
    input  logic             term_evt,
    input  logic             udf_evt,
    input  logic [CNT_W-1:0] udf_cnt,
    input  logic             ovf_clr,
    output logic             sts_o,
    output logic             term_o,
    output logic [CNT_W-1:0] prd_o
);
    typedef struct packed {
        logic             sts;
        logic             term;
        logic [CNT_W-1:0] prd;
    } sts_state_t;

    sts_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (st_q.sts && !ovf_clr) || ovf_evt;
        if (cmd_start) begin
            st_d.term = 1'b0;
            st_d.prd  = cmd_budget;
        end else begin
            if (term_evt) st_d.term = 1'b1;
            if (udf_evt)  st_d.prd  = udf_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o  = st_q.sts;
    assign term_o = st_q.term;
    assign prd_o  = st_q.prd;

endmodule

// File: rtl/tovf_monitor.sv
module tovf_monitor
    import tovf_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int FRM_W    = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_budget,
    input  logic             cmd_is_read,
    input  logic             cmd_is_dma,
    input  logic             cmd_queued,
    input  logic             frm_valid,
    input  logic [FRM_W-1:0] frm_bytes,
    input  logic             frm_last,
    input  logic             dma_activate,
    input  logic             pio_setup,
    input  logic [FRM_W-1:0] pio_xfer_len,
    input  logic             wr_ovf_chk_en,
    input  logic             port_ovf_ie,
    input  logic             glb_ie,
    input  logic             ovf_clr,
    output logic             ovf_status,
    output logic             ovf_irq,
    output logic [CNT_W-1:0] prd_byte_cnt,
    output logic             xfer_term_req
);
    cmd_attr_t        attr;
    logic [CNT_W-1:0] budget, total, sum, udf_cnt;
    logic             frm_acc, ovf_evt, term_evt, udf_evt;

    tovf_tracker #(.CNT_W(CNT_W), .FRM_W(FRM_W), .SATURATE(SATURATE)) u_trk (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_budget(cmd_budget),
        .cmd_is_read(cmd_is_read), .cmd_is_dma(cmd_is_dma), .cmd_queued(cmd_queued),
        .frm_valid(frm_valid), .frm_bytes(frm_bytes), .frm_last(frm_last),
        .attr_o(attr), .budget_o(budget), .total_o(total), .sum_o(sum),
        .frm_acc_o(frm_acc)
    );

    tovf_detect #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_det (
        .attr(attr), .budget(budget), .total(total), .sum(sum), .frm_acc(frm_acc),
        .frm_last(frm_last), .cmd_start(cmd_start), .dma_activate(dma_activate),
        .pio_setup(pio_setup), .pio_xfer_len(pio_xfer_len),
        .wr_ovf_chk_en(wr_ovf_chk_en), .ovf_evt(ovf_evt), .term_evt(term_evt),
        .udf_evt(udf_evt), .udf_cnt(udf_cnt)
    );

    tovf_status #(.CNT_W(CNT_W)) u_sts (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_budget(cmd_budget),
        .ovf_evt(ovf_evt), .term_evt(term_evt), .udf_evt(udf_evt), .udf_cnt(udf_cnt),
        .ovf_clr(ovf_clr), .sts_o(ovf_status), .term_o(xfer_term_req),
        .prd_o(prd_byte_cnt)
    );

    assign ovf_irq = ovf_status && port_ovf_ie && glb_ie;

endmodule

// File: rtl/tovf_monitor_chk.sv
module tovf_monitor_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [CNT_W-1:0] cmd_budget,
    input logic             dma_activate,
    input logic             port_ovf_ie,
    input logic             glb_ie,
    input logic             ovf_clr,
    input logic             ovf_evt,
    input logic             ovf_status,
    input logic             ovf_irq,
    input logic [CNT_W-1:0] prd_byte_cnt,
    input logic             xfer_term_req
);
    // R4: the request never appears without status and both enables
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (ovf_status && port_ovf_ie && glb_ie));

    // R5: status holds until cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_status && !ovf_clr) |=> ovf_status);

    // R5: a clear with no competing event drops the status
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_evt) |=> !ovf_status);

    // R2: start loads the byte count and drops termination
    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> ((prd_byte_cnt == $past(cmd_budget)) && !xfer_term_req));

    // R6: termination holds until the next start
    a_r6_term_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_term_req && !cmd_start) |=> xfer_term_req);

    // R6: termination only rises after a DMA-activate
    a_r6_term_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_term_req) |-> $past(dma_activate));

    // R6: a raised termination is always accompanied by status
    a_r6_term_sts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_term_req) |-> ovf_status);

endmodule

bind tovf_monitor tovf_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_budget(cmd_budget),
    .dma_activate(dma_activate), .port_ovf_ie(port_ovf_ie), .glb_ie(glb_ie),
    .ovf_clr(ovf_clr), .ovf_evt(ovf_evt), .ovf_status(ovf_status),
    .ovf_irq(ovf_irq), .prd_byte_cnt(prd_byte_cnt), .xfer_term_req(xfer_term_req)
);

// File: tb/tovf_monitor_tb_top.sv
`timescale 1ns/1ps
module tovf_monitor_tb_top;
    localparam int CNT_W = 24;
    localparam int FRM_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0;
    logic [CNT_W-1:0] cmd_budget = '0;
    logic             cmd_is_read = 1'b0, cmd_is_dma = 1'b0, cmd_queued = 1'b0;
    logic             frm_valid = 1'b0, frm_last = 1'b0;
    logic [FRM_W-1:0] frm_bytes = '0;
    logic             dma_activate = 1'b0, pio_setup = 1'b0;
    logic [FRM_W-1:0] pio_xfer_len = '0;
    logic             wr_ovf_chk_en = 1'b1, port_ovf_ie = 1'b1, glb_ie = 1'b1;
    logic             ovf_clr = 1'b0;
    logic             ovf_status, ovf_irq, xfer_term_req;
    logic [CNT_W-1:0] prd_byte_cnt;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tovf_monitor #(.CNT_W(CNT_W), .FRM_W(FRM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_budget(cmd_budget),
        .cmd_is_read(cmd_is_read), .cmd_is_dma(cmd_is_dma), .cmd_queued(cmd_queued),
        .frm_valid(frm_valid), .frm_bytes(frm_bytes), .frm_last(frm_last),
        .dma_activate(dma_activate), .pio_setup(pio_setup), .pio_xfer_len(pio_xfer_len),
        .wr_ovf_chk_en(wr_ovf_chk_en), .port_ovf_ie(port_ovf_ie), .glb_ie(glb_ie),
        .ovf_clr(ovf_clr), .ovf_status(ovf_status), .ovf_irq(ovf_irq),
        .prd_byte_cnt(prd_byte_cnt), .xfer_term_req(xfer_term_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input int budget, input bit rd, input bit dma, input bit q);
        @(negedge clk);
        cmd_start = 1'b1; cmd_budget = budget[CNT_W-1:0];
        cmd_is_read = rd; cmd_is_dma = dma; cmd_queued = q;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic frame(input int bytes, input bit last);
        @(negedge clk);
        frm_valid = 1'b1; frm_bytes = bytes[FRM_W-1:0]; frm_last = last;
        @(negedge clk);
        frm_valid = 1'b0; frm_last = 1'b0;
    endtask

    task automatic dma_act();
        @(negedge clk); dma_activate = 1'b1;
        @(negedge clk); dma_activate = 1'b0;
    endtask

    task automatic pio_set(input int len);
        @(negedge clk); pio_setup = 1'b1; pio_xfer_len = len[FRM_W-1:0];
        @(negedge clk); pio_setup = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", ovf_status, 0);
        check("R1 irq", ovf_irq, 0);
        check("R1 term", xfer_term_req, 0);
        check("R1 count", prd_byte_cnt, 0);
    endtask

    task automatic t_read_under();
        start_cmd(1000, 1, 0, 0);
        check("R2 load", prd_byte_cnt, 1000);
        frame(400, 0);
        frame(300, 1);
        check("R9 underflow count", prd_byte_cnt, 700);
        check("R9 no ovf", ovf_status, 0);
        frame(5000, 1);  // after last frame
        check("R12 idle count", prd_byte_cnt, 700);
        check("R12 idle status", ovf_status, 0);
        start_cmd(512, 1, 1, 0);
        frame(256, 0);
        frame(256, 1);
        check("R9 exact count", prd_byte_cnt, 512);
    endtask

    task automatic t_read_over_pio();
        port_ovf_ie = 1'b0; glb_ie = 1'b0;
        start_cmd(500, 1, 0, 0);
        frame(300, 0);
        check("R3 below", ovf_status, 0);
        frame(300, 0);
        check("R3 pio read ovf", ovf_status, 1);
        #0.1 check("R4 both off", ovf_irq, 0);
        port_ovf_ie = 1'b1;
        #0.1 check("R4 port only", ovf_irq, 0);
        glb_ie = 1'b1; port_ovf_ie = 1'b0;
        #0.1 check("R4 global only", ovf_irq, 0);
        port_ovf_ie = 1'b1;
        #0.1 check("R4 both on", ovf_irq, 1);
        frame(100, 1);
        check("R11 status kept", ovf_status, 1);
        check("R11 no term", xfer_term_req, 0);
        check("R11 count unchanged", prd_byte_cnt, 500);
        repeat (3) @(negedge clk);
        check("R5 sticky", ovf_status, 1);
        clear_sts();
        check("R5 cleared", ovf_status, 0);
        check("R4 irq follows", ovf_irq, 0);
    endtask

    task automatic t_read_over_dma();
        start_cmd(64, 1, 1, 0);
        frame(65, 1);
        check("R3 dma read ovf", ovf_status, 1);
        check("R9 no load on ovf", prd_byte_cnt, 64);
        clear_sts();
    endtask

    task automatic t_dma_write();
        start_cmd(600, 0, 1, 0);
        dma_act();
        check("R6 activate under budget", ovf_status, 0);
        check("R6 no term under budget", xfer_term_req, 0);
        frame(600, 0);
        check("R9 write no load", prd_byte_cnt, 600);
        dma_act();
        check("R6 dma write ovf", ovf_status, 1);
        check("R6 term raised", xfer_term_req, 1);
        clear_sts();
        check("R6 term held", xfer_term_req, 1);
        start_cmd(200, 0, 0, 0);
        check("R2 term dropped", xfer_term_req, 0);
        frame(100, 1);
        check("R9 pio write short no load", prd_byte_cnt, 200);
    endtask

    task automatic t_pio_write();
        start_cmd(400, 0, 0, 0);
        pio_set(400);
        check("R7 fits", ovf_status, 0);
        frame(400, 0);
        pio_set(4);
        check("R7 pio write ovf", ovf_status, 1);
        check("R7 no term", xfer_term_req, 0);
        clear_sts();
    endtask

    task automatic t_wr_disabled();
        wr_ovf_chk_en = 1'b0;
        start_cmd(100, 0, 1, 0);
        frame(100, 0);
        dma_act();
        check("R8 dma status", ovf_status, 0);
        check("R8 dma term", xfer_term_req, 0);
        start_cmd(100, 0, 0, 0);
        pio_set(300);
        check("R8 pio status", ovf_status, 0);
        wr_ovf_chk_en = 1'b1;
    endtask

    task automatic t_queued();
        start_cmd(100, 1, 1, 1);
        frame(300, 0);
        check("R10 read ovf bypass", ovf_status, 0);
        start_cmd(100, 1, 1, 1);
        frame(50, 1);
        check("R10 read udf bypass", prd_byte_cnt, 100);
        start_cmd(10, 0, 1, 1);
        frame(20, 0);
        dma_act();
        check("R10 dma status bypass", ovf_status, 0);
        check("R10 dma term bypass", xfer_term_req, 0);
    endtask

    task automatic t_set_wins();
        start_cmd(10, 1, 0, 0);
        @(negedge clk);
        frm_valid = 1'b1; frm_bytes = 16'd20; ovf_clr = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0; ovf_clr = 1'b0;
        check("R5 set wins", ovf_status, 1);
        clear_sts();
        check("R5 clear after", ovf_status, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_under();
        t_read_over_pio();
        t_read_over_dma();
        t_dma_write();
        t_pio_write();
        t_wr_disabled();
        t_queued();
        t_set_wins();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule